// File: doc/BRIEF.md
# Key-Guarded Register Write Protection

This block guards a small bank of configuration registers. A software-visible lock bit decides whether writes to the registers marked as protected reach their targets. The lock bit sits in a lock-control register and changes only when the write also carries a fixed 24-bit unlock key in its upper bits. While the lock is on, a write to a protected entry is dropped, and a violation record notes that it happened and which offset was hit. Software clears the record by reading it.

The register bus has separate write and read addresses so that a write and a read can occur in the same cycle. A per-entry mask input marks which array entries are protected. The block drives a write-allow strobe to the array and returns read data one cycle after a read request. It also presents the violation record directly on output pins.

Top module: `wprot_guard`

## Requirements
- R1: After reset the lock is off, the violation flag and source are zero, every array entry reads as zero and `rd_data` is zero.
- R2: A write to the lock-control address (`MODE_ADDR`) whose bits 31:8 equal 0x4D4154 loads bit 0 of the write data into the lock bit. The new value governs writes from the next cycle.
- R3: A write to the lock-control address with any other value in bits 31:8 leaves the lock bit unchanged.
- R4: A read of the lock-control address returns the lock bit in bit 0 and zero in bits 31:1, so the key field always reads zero.
- R5: While the lock is on, a write to an array entry whose `prot_mask` bit is 1 is dropped. In that cycle `wr_allow` is low, and the entry keeps its old value.
- R6: A dropped write sets the violation flag and loads the write address, zero-extended, into the 16-bit source. Both are visible on `viol_flag` and `viol_src` in the cycle after the write.
- R7: A read of the status address (`STAT_ADDR`) returns the flag in bit 0 and the source in bits 23:8, with all other bits zero. It then clears the flag and the source.
- R8: If a write is dropped in the same cycle as a status read, the read returns the old record and the new violation is kept.
- R9: While the lock is on, writes to unprotected entries are accepted, and writes to the lock-control address are never blocked.
- R10: While the lock is off, every array write is accepted and no violation is recorded.
- R11: Read data appears on `rd_data` exactly one cycle after `rd_en` and is zero in any cycle that follows no read. Writes to the status address have no effect.
- R12: A later violation replaces the source of an earlier one that has not yet been read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Word address of the read |
| prot_mask | input | NUM_REGS | 1 marks an array entry as protected |
| wr_allow | output | 1 | Write to an array entry accepted this cycle |
| rd_data | output | 32 | Registered read data |
| viol_flag | output | 1 | Violation recorded and not yet read |
| viol_src | output | 16 | Offset of the latest dropped write |

## Verification
The bench targets the cases where the key test, the lock and the status record interact. A key compare that looked at too few bits, or ignored the key altogether, would change the lock on a wrong key. A read-clear that took priority over capture would lose a violation that arrives in the same cycle as a status read. A source register that held its first value would report a stale offset after a second violation. Treating the lock-control address as protected would make the lock impossible to release, and leaking key bits into the readback would show nonzero upper bits on a lock-control read.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam int WORD_W  = 32;
    localparam int KEY_W   = 24;
    localparam int KEY_LSB = 8;
    localparam int SRC_W   = 16;
    localparam int SRC_LSB = 8;

    localparam logic [KEY_W-1:0] UNLOCK_KEY = 24'h4D4154;

    // Lock bit plus the violation record
    typedef struct packed {
        logic             en;
        logic             flag;
        logic [SRC_W-1:0] src;
    } guard_state_t;

endpackage

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_REGS  = 8,
    parameter int MODE_ADDR = 48,
    parameter int STAT_ADDR = 49,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_REGS-1:0] prot_mask,
    output logic                wr_allow,
    output logic [IDX_W-1:0]    wr_idx,
    output logic                prot_en,
    output logic                viol_flag,
    output logic [SRC_W-1:0]    viol_src
);

    localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    guard_state_t st_d, st_q;
    logic         arr_hit;
    logic         blocked;
    logic         key_ok;

    always_comb begin
        wr_idx   = wr_addr[IDX_W-1:0];
        arr_hit  = wr_en && (wr_addr < NREG_A);
        blocked  = arr_hit && st_q.en && prot_mask[wr_idx];
        wr_allow = arr_hit && !blocked;
        key_ok   = (wr_data[WORD_W-1:KEY_LSB] == UNLOCK_KEY);

        st_d = st_q;
        if (wr_en && (wr_addr == MODE_A) && key_ok) begin
            st_d.en = wr_data[0];
        end
        // capture outranks the clear-on-read
        if (blocked) begin
            st_d.flag = 1'b1;
            st_d.src  = SRC_W'(wr_addr);
        end else if (rd_en && (rd_addr == STAT_A)) begin
            st_d.flag = 1'b0;
            st_d.src  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot_en   = st_q.en;
    assign viol_flag = st_q.flag;
    assign viol_src  = st_q.src;

    assert_bad_key_keeps_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == MODE_A && wr_data[WORD_W-1:KEY_LSB] != UNLOCK_KEY)
        |=> $stable(prot_en));

    assert_capture_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < NREG_A && prot_en && prot_mask[wr_addr[IDX_W-1:0]])
        |=> (viol_flag && viol_src == SRC_W'($past(wr_addr))));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == STAT_A && !(wr_en && wr_addr < NREG_A && prot_en))
        |=> (!viol_flag && viol_src == '0));

    assert_no_viol_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_flag) |-> $past(prot_en));

endmodule

// File: rtl/wprot_regfile.sv
module wprot_regfile
    import wprot_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [WORD_W-1:0]               wr_data,
    output logic [NUM_REGS-1:0][WORD_W-1:0] words
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        logic [WORD_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign words[g] = ent_q;
    end

    assert_dropped_write_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(words));

endmodule

// File: rtl/wprot_rdmux.sv
module wprot_rdmux
    import wprot_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_REGS  = 8,
    parameter int MODE_ADDR = 48,
    parameter int STAT_ADDR = 49,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [NUM_REGS-1:0][WORD_W-1:0] words,
    input  logic                            prot_en,
    input  logic                            viol_flag,
    input  logic [SRC_W-1:0]                viol_src,
    output logic [WORD_W-1:0]               rd_data
);

    localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    logic [WORD_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (rd_en) begin
            if (rd_addr < NREG_A) begin
                rd_d = words[rd_addr[IDX_W-1:0]];
            end else if (rd_addr == MODE_A) begin
                rd_d[0] = prot_en;
            end else if (rd_addr == STAT_A) begin
                rd_d[0]                = viol_flag;
                rd_d[SRC_LSB +: SRC_W] = viol_src;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

    assert_key_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == MODE_A) |=> (rd_data[WORD_W-1:1] == '0));

    assert_idle_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

endmodule

// File: rtl/wprot_guard.sv
module wprot_guard
    import wprot_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_REGS  = 8,
    parameter int MODE_ADDR = 48,
    parameter int STAT_ADDR = 49
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [31:0]         wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_REGS-1:0] prot_mask,
    output logic                wr_allow,
    output logic [31:0]         rd_data,
    output logic                viol_flag,
    output logic [15:0]         viol_src
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [IDX_W-1:0]                wr_idx;
    logic                            prot_en;
    logic [NUM_REGS-1:0][WORD_W-1:0] words;

    wprot_ctrl #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .MODE_ADDR(MODE_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .prot_mask(prot_mask),
        .wr_allow (wr_allow),
        .wr_idx   (wr_idx),
        .prot_en  (prot_en),
        .viol_flag(viol_flag),
        .viol_src (viol_src)
    );

    wprot_regfile #(
        .NUM_REGS(NUM_REGS)
    ) i_regfile (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_allow),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .words  (words)
    );

    wprot_rdmux #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .MODE_ADDR(MODE_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) i_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .words    (words),
        .prot_en  (prot_en),
        .viol_flag(viol_flag),
        .viol_src (viol_src),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/test_wprot_guard.sv
module test_wprot_guard;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int NUM_REGS   = 8;
    localparam int MODE_ADDR  = 48;
    localparam int STAT_ADDR  = 49;
    localparam logic [23:0] KEY = 24'h4D4154;

    logic                clk;
    logic                rst_n;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [31:0]         wr_data;
    logic                rd_en;
    logic [ADDR_W-1:0]   rd_addr;
    logic [NUM_REGS-1:0] prot_mask;
    logic                wr_allow;
    logic [31:0]         rd_data;
    logic                viol_flag;
    logic [15:0]         viol_src;

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 0;

    // behavioural reference state
    bit          m_en;
    bit          m_flag;
    int          m_src;
    logic [31:0] m_regs [NUM_REGS];
    logic [31:0] m_rd;

    wprot_guard #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .MODE_ADDR(MODE_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) i_wprot_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .prot_mask(prot_mask),
        .wr_allow (wr_allow),
        .rd_data  (rd_data),
        .viol_flag(viol_flag),
        .viol_src (viol_src)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
        logic [31:0] v;
        v = 32'h0;
        if (a < NUM_REGS) v = m_regs[a];
        else if (a == MODE_ADDR) v = {31'h0, m_en};
        else if (a == STAT_ADDR) v = {8'h0, m_src[15:0], 7'h0, m_flag};
        return v;
    endfunction

    // one bus cycle: drive, check strobe, clock, update model, check outputs
    task automatic step(input string tag, input bit we, input int wa, input logic [31:0] wd,
                        input bit re, input int ra);
        bit arr;
        bit blk;
        wr_en   = we;
        wr_addr = ADDR_W'(wa);
        wr_data = wd;
        rd_en   = re;
        rd_addr = ADDR_W'(ra);
        #1;
        arr = we && (wa < NUM_REGS);
        blk = arr && m_en && prot_mask[wa % NUM_REGS];
        chk(tag, "wr_allow", {31'h0, wr_allow}, {31'h0, arr && !blk});
        @(posedge clk);
        m_rd = re ? model_read(ADDR_W'(ra)) : 32'h0;
        if (arr && !blk) m_regs[wa] = wd;
        if (we && wa == MODE_ADDR && wd[31:8] == KEY) m_en = wd[0];
        if (blk) begin
            m_flag = 1'b1;
            m_src  = wa;
        end else if (re && ra == STAT_ADDR) begin
            m_flag = 1'b0;
            m_src  = 0;
        end
        @(negedge clk);
        chk(tag, "rd_data", rd_data, m_rd);
        chk(tag, "viol_flag", {31'h0, viol_flag}, {31'h0, m_flag});
        chk(tag, "viol_src", {16'h0, viol_src}, 32'(m_src));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        rd_en     = 1'b0;
        rd_addr   = '0;
        prot_mask = 8'b0000_0110;
        m_en = 0; m_flag = 0; m_src = 0; m_rd = 0;
        for (int i = 0; i < NUM_REGS; i++) m_regs[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", "rd_data", rd_data, 32'h0);
        chk("R1", "viol_flag", {31'h0, viol_flag}, 32'h0);
        chk("R1", "viol_src", {16'h0, viol_src}, 32'h0);
        step("R1", 0, 0, 0, 1, MODE_ADDR);
        chk("R1", "lock after reset", rd_data, 32'h0);
        step("R1", 0, 0, 0, 1, 3);

        // R10: unlocked, protected entries accept writes
        step("R10", 1, 1, 32'hAAAA_0001, 0, 0);
        step("R10", 1, 2, 32'hBBBB_0002, 1, 1);
        chk("R10", "entry1 written", rd_data, 32'hAAAA_0001);
        step("R10", 1, 3, 32'hCCCC_0003, 0, 0);

        // R3: wrong key leaves lock off
        step("R3", 1, MODE_ADDR, {24'h4D4155, 8'h01}, 0, 0);
        step("R3", 1, MODE_ADDR, {24'h000000, 8'h01}, 1, MODE_ADDR);
        chk("R3", "lock unchanged", rd_data, 32'h0);

        // R2 / R4: correct key arms lock; readback hides key
        step("R2", 1, MODE_ADDR, {KEY, 8'hFF}, 0, 0);
        step("R4", 0, 0, 0, 1, MODE_ADDR);
        chk("R4", "lock readback", rd_data, 32'h1);

        // R5 / R6: protected write dropped and recorded
        step("R5", 1, 1, 32'hDEAD_BEEF, 0, 0);
        chk("R6", "flag set", {31'h0, viol_flag}, 32'h1);
        chk("R6", "source", {16'h0, viol_src}, 32'h1);
        step("R5", 0, 0, 0, 1, 1);
        chk("R5", "entry1 kept", rd_data, 32'hAAAA_0001);

        // R9: unprotected entry and lock register still writable
        step("R9", 1, 0, 32'h1234_5678, 1, 0);
        step("R9", 0, 0, 0, 1, 0);
        chk("R9", "entry0 written", rd_data, 32'h1234_5678);

        // R12: later violation replaces source
        step("R12", 1, 2, 32'h0BAD_0BAD, 0, 0);
        chk("R12", "source updated", {16'h0, viol_src}, 32'h2);

        // R11: status writes ignored
        step("R11", 1, STAT_ADDR, 32'hFFFF_FFFF, 0, 0);
        chk("R11", "status held", {16'h0, viol_src}, 32'h2);

        // R7: status read returns record and clears it
        step("R7", 0, 0, 0, 1, STAT_ADDR);
        chk("R7", "status word", rd_data, 32'h0000_0201);
        chk("R7", "cleared flag", {31'h0, viol_flag}, 32'h0);
        step("R7", 0, 0, 0, 1, STAT_ADDR);
        chk("R7", "second read", rd_data, 32'h0);

        // R8: violation coinciding with status read wins
        step("R8", 1, 1, 32'h1111_1111, 0, 0);
        step("R8", 1, 2, 32'h2222_2222, 1, STAT_ADDR);
        chk("R8", "old record returned", rd_data, 32'h0000_0101);
        chk("R8", "new flag kept", {31'h0, viol_flag}, 32'h1);
        chk("R8", "new source kept", {16'h0, viol_src}, 32'h2);

        // R9: lock released while locked, then protected write accepted
        step("R9", 1, MODE_ADDR, {KEY, 8'h00}, 0, 0);
        step("R9", 1, 1, 32'h5555_AAAA, 1, STAT_ADDR);
        step("R9", 0, 0, 0, 1, 1);
        chk("R9", "entry1 after unlock", rd_data, 32'h5555_AAAA);

        // mixed traffic against the reference model
        for (int i = 0; i < 600; i++) begin
            int          wa;
            int          ra;
            logic [31:0] wd;
            int          sel;
            if (i % 60 == 0) prot_mask = NUM_REGS'($urandom);
            sel = int'($urandom_range(0, 9));
            wa  = (sel < 7) ? int'($urandom_range(0, NUM_REGS - 1))
                : (sel < 9) ? MODE_ADDR : STAT_ADDR;
            ra  = int'($urandom_range(0, 3));
            ra  = (ra == 0) ? MODE_ADDR : (ra == 1) ? STAT_ADDR
                : int'($urandom_range(0, NUM_REGS + 1));
            wd  = $urandom;
            if (wa == MODE_ADDR && $urandom_range(0, 1) == 1) wd[31:8] = KEY;
            step("R6", bit'($urandom_range(0, 1)), wa, wd, bit'($urandom_range(0, 1)), ra);
        end

        finish_run();
    end

endmodule